// File: doc/BRIEF.md
# Per-Packet Resolution and Sample-Rate Controller

This block sets the precision and the sample rate of a low-power receiver datapath, one packet at a time. It runs on a 30 MHz master clock. Whenever the receiver is waiting for a packet, and while a preamble is in progress, the block uses full settings: 8-bit samples on every master cycle. While the preamble runs, an external estimator produces an interference level and a signal level. When the preamble ends, the block uses these two levels to read a small settings table. The resolution and rate held in that entry then stay in force for the rest of the packet. An end-of-packet strobe returns the block to full settings.

The block contains the word-length reducer and the rate divider. The reducer keeps Q significant bits of each 8-bit sample by shifting it arithmetically right by 8−Q places. The upper bits then only carry sign copies and stop toggling. The divider gives a one-cycle sample enable once every N master cycles, where N is 1, 2, 3, 5, 6, 10 or 15. These ratios give rates of 30, 15, 10, 6, 5, 3 and 2 MHz. A new ratio takes effect only at a divider terminal count. Software can rewrite the table through a write port.

Top module: `adaptive_rx_ctrl`

## Requirements
- R1: After reset, `res_o` is 3 (8 bits), `div_o` is 1, and `smp_en_o` is high on every cycle.
- R2: `smp_en_o` is a one-cycle pulse. Two successive pulses are exactly D cycles apart, where D is the `div_o` value shown during the first of the two pulses.
- R3: On each `smp_en_o` pulse, `smp_o` equals the `smp_i` value sampled at that divider tick, shifted arithmetically right by 8−Q. Q is 1, 2, 4 or 8 for resolution codes 0, 1, 2 or 3. Between pulses, `smp_o` holds its value.
- R4: A `pre_start_i` strobe enters the preamble and restores full settings: resolution code 3 and ratio 1. It takes priority over the other strobes.
- R5: A `pre_end_i` strobe during the preamble reads the entry at index {`intf_i`,`snr_i`}. Its resolution shows on `res_o` in the next cycle. Its ratio shows on `div_o` at the next terminal count.
- R6: The table resets to these entries, where a level is high when its MSB is 1. High interference with low SNR gives 8 bits at ratio 2. Low interference with low SNR gives 2 bits at ratio 2. High SNR at any interference gives 1 bit at ratio 15.
- R7: `tbl_we_i` writes `tbl_wdata_i` to the entry at `tbl_addr_i`. The data bits [4:2] hold the rate code and bits [1:0] hold the resolution code. Rate codes 0 to 6 select ratios 1, 2, 3, 5, 6, 10 and 15.
- R8: An entry with rate code 7 has no valid setting. Selecting it falls back to resolution code 3 and ratio 1.
- R9: `div_o` changes only in a cycle in which `smp_en_o` is high. This means no sample period is ever shortened.
- R10: A `pkt_end_i` strobe restores full settings. A `pre_end_i` strobe outside the preamble is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 30 MHz master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_start_i | input | 1 | Preamble start strobe |
| pre_end_i | input | 1 | Preamble end strobe |
| pkt_end_i | input | 1 | Packet end strobe |
| intf_i | input | 1 | Interference level from the estimator |
| snr_i | input | 1 | Signal level from the estimator |
| tbl_we_i | input | 1 | Table write enable |
| tbl_addr_i | input | 2 | Table write index {interference, signal} |
| tbl_wdata_i | input | 5 | Entry: rate code [4:2], resolution code [1:0] |
| smp_i | input | 8 | Signed input sample |
| smp_o | output | 8 | Reduced, sign-extended sample |
| smp_en_o | output | 1 | Sample enable, one cycle per sample period |
| res_o | output | 2 | Current resolution code |
| div_o | output | 4 | Applied divide ratio |

## Verification
The strobes and table writes act at the next clock edge. A new resolution is therefore due on `res_o` one cycle after its strobe. A new ratio is due only at the next terminal count. The reduced sample and its enable appear one cycle after the divider tick that captured the sample. The bench drives inputs on falling edges and reads outputs on the following falling edge. It does not check a ratio straight after a change: it lets one sample period pass, then measures the spacing between two enable pulses. It checks `smp_o` in a cycle where the enable is high.

// File: rtl/rrc_pkg.sv
package rrc_pkg;
  localparam int SMP_W   = 8;
  localparam int RATIO_W = 4;

  typedef logic [1:0] res_t;
  typedef logic [2:0] rate_t;

  typedef struct packed {
    rate_t rate;
    res_t  res;
  } cfg_t;

  localparam res_t  RES_FULL  = 2'd3;
  localparam rate_t RATE_FULL = 3'd0;
  localparam rate_t RATE_NONE = 3'd7;

  // rate code to master-clock divide ratio
  function automatic logic [RATIO_W-1:0] rate_ratio(rate_t c);
    case (c)
      3'd0:    return 4'd1;
      3'd1:    return 4'd2;
      3'd2:    return 4'd3;
      3'd3:    return 4'd5;
      3'd4:    return 4'd6;
      3'd5:    return 4'd10;
      3'd6:    return 4'd15;
      default: return 4'd1;
    endcase
  endfunction

  // resolution code to right-shift amount (8 - Q)
  function automatic logic [2:0] res_shift(res_t r);
    case (r)
      2'd0:    return 3'd7;
      2'd1:    return 3'd6;
      2'd2:    return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic cfg_t default_cfg(logic intf_hi, logic snr_hi);
    cfg_t c;
    if (snr_hi)       c = '{rate: 3'd6, res: 2'd0};
    else if (intf_hi) c = '{rate: 3'd1, res: 2'd3};
    else              c = '{rate: 3'd1, res: 2'd1};
    return c;
  endfunction
endpackage

// File: rtl/rrc_table.sv
module rrc_table
  import rrc_pkg::*;
#(
  parameter int INTF_W = 1,
  parameter int SNR_W  = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [INTF_W+SNR_W-1:0]  waddr,
  input  cfg_t                     wdata,
  input  logic [INTF_W-1:0]        intf,
  input  logic [SNR_W-1:0]         snr,
  output cfg_t                     rd
);
  localparam int IDX_W = INTF_W + SNR_W;
  localparam int DEPTH = 1 << IDX_W;

  cfg_t ent_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    localparam logic [IDX_W-1:0] IDX = IDX_W'(i);
    localparam logic INTF_HI = IDX[IDX_W-1];
    localparam logic SNR_HI  = IDX[SNR_W-1];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  ent_q[i] <= default_cfg(INTF_HI, SNR_HI);
      else if (we && waddr == IDX) ent_q[i] <= wdata;
    end
  end

  cfg_t raw;
  always_comb begin
    raw = ent_q[{intf, snr}];
    if (raw.rate == RATE_NONE) rd = '{rate: RATE_FULL, res: RES_FULL};
    else                       rd = raw;
  end
endmodule

// File: rtl/rrc_rate_div.sv
module rrc_rate_div
  import rrc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] tgt_ratio,
  output logic               tick_o,
  output logic [RATIO_W-1:0] ratio_o
);
  logic [RATIO_W-1:0] cnt_q, cnt_d, ratio_q, ratio_d;

  assign tick_o  = (cnt_q == '0);
  assign ratio_o = ratio_q;

  always_comb begin
    cnt_d   = cnt_q;
    ratio_d = ratio_q;
    if (tick_o) begin
      ratio_d = tgt_ratio;
      cnt_d   = tgt_ratio - 1'b1;
    end else begin
      cnt_d   = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= RATIO_W'(1);
    end else begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
    end
  end
endmodule

// File: rtl/rrc_wl_shift.sv
module rrc_wl_shift
  import rrc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  res_t             res,
  input  logic [SMP_W-1:0] din,
  output logic [SMP_W-1:0] dout,
  output logic             vld_o
);
  logic [SMP_W-1:0] dat_q, dat_d;
  logic             vld_q;

  always_comb begin
    dat_d = dat_q;
    if (en) dat_d = SMP_W'($signed(din) >>> res_shift(res));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
      vld_q <= 1'b0;
    end else begin
      dat_q <= dat_d;
      vld_q <= en;
    end
  end

  assign dout  = dat_q;
  assign vld_o = vld_q;
endmodule

// File: rtl/adaptive_rx_ctrl.sv
module adaptive_rx_ctrl
  import rrc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pre_start_i,
  input  logic        pre_end_i,
  input  logic        pkt_end_i,
  input  logic        intf_i,
  input  logic        snr_i,
  input  logic        tbl_we_i,
  input  logic [1:0]  tbl_addr_i,
  input  logic [4:0]  tbl_wdata_i,
  input  logic [7:0]  smp_i,
  output logic [7:0]  smp_o,
  output logic        smp_en_o,
  output logic [1:0]  res_o,
  output logic [3:0]  div_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_PAY} st_t;

  st_t  st_q, st_d;
  cfg_t cfg_q, cfg_d, tbl_rd;
  logic tick;

  rrc_table #(.INTF_W(1), .SNR_W(1)) u_tbl (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (tbl_we_i),
    .waddr (tbl_addr_i),
    .wdata (cfg_t'(tbl_wdata_i)),
    .intf  (intf_i),
    .snr   (snr_i),
    .rd    (tbl_rd)
  );

  always_comb begin
    st_d  = st_q;
    cfg_d = cfg_q;
    if (pre_start_i) begin
      st_d  = ST_PRE;
      cfg_d = '{rate: RATE_FULL, res: RES_FULL};
    end else if (pkt_end_i) begin
      st_d  = ST_IDLE;
      cfg_d = '{rate: RATE_FULL, res: RES_FULL};
    end else if (pre_end_i && st_q == ST_PRE) begin
      st_d  = ST_PAY;
      cfg_d = tbl_rd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cfg_q <= '{rate: RATE_FULL, res: RES_FULL};
    end else begin
      st_q  <= st_d;
      cfg_q <= cfg_d;
    end
  end

  rrc_rate_div u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .tgt_ratio (rate_ratio(cfg_q.rate)),
    .tick_o    (tick),
    .ratio_o   (div_o)
  );

  rrc_wl_shift u_wl (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (tick),
    .res   (cfg_q.res),
    .din   (smp_i),
    .dout  (smp_o),
    .vld_o (smp_en_o)
  );

  assign res_o = cfg_q.res;
endmodule

// File: rtl/rrc_checker.sv
module rrc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       pre_start_i,
  input logic       pkt_end_i,
  input logic [7:0] smp_o,
  input logic       smp_en_o,
  input logic [1:0] res_o,
  input logic [3:0] div_o
);
  logic [4:0] gap_q;
  logic [3:0] gap_div_q;
  logic       seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q     <= '0;
      gap_div_q <= '0;
      seen_q    <= 1'b0;
    end else if (smp_en_o) begin
      gap_q     <= 5'd1;
      gap_div_q <= div_o;
      seen_q    <= 1'b1;
    end else if (gap_q != 5'd31) begin
      gap_q     <= gap_q + 5'd1;
    end
  end

  function automatic logic fits(logic [7:0] d, logic [1:0] r);
    int q, v;
    q = 1 << r;
    v = int'($signed(d));
    return (v >= -(1 << (q - 1))) && (v < (1 << (q - 1)));
  endfunction

  // R2
  en_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && smp_en_o) |-> ({1'b0, gap_div_q} == gap_q));

  // R9
  ratio_at_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en_o |-> $stable(div_o));

  // R3
  smp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_en_o |-> fits(smp_o, $past(res_o)));

  // R3
  smp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en_o |-> $stable(smp_o));

  // R4
  start_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_start_i |=> (res_o == 2'd3));

  // R10
  end_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end_i |=> (res_o == 2'd3));
endmodule

bind adaptive_rx_ctrl rrc_checker u_rrc_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .pre_start_i (pre_start_i),
  .pkt_end_i   (pkt_end_i),
  .smp_o       (smp_o),
  .smp_en_o    (smp_en_o),
  .res_o       (res_o),
  .div_o       (div_o)
);

// File: tb/test_adaptive_rx_ctrl.sv
module test_adaptive_rx_ctrl;
  localparam time CLK_PERIOD = 33ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pre_start_i = 1'b0, pre_end_i = 1'b0, pkt_end_i = 1'b0;
  logic       intf_i = 1'b0, snr_i = 1'b0;
  logic       tbl_we_i = 1'b0;
  logic [1:0] tbl_addr_i = '0;
  logic [4:0] tbl_wdata_i = '0;
  logic [7:0] smp_i = '0;
  logic [7:0] smp_o;
  logic       smp_en_o;
  logic [1:0] res_o;
  logic [3:0] div_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adaptive_rx_ctrl i_adaptive_rx_ctrl (.*);

  function automatic int exp_ratio(int code);
    case (code)
      0: return 1;  1: return 2;  2: return 3;  3: return 5;
      4: return 6;  5: return 10; 6: return 15; default: return 1;
    endcase
  endfunction

  function automatic logic [7:0] exp_smp(logic [7:0] v, int res);
    int sh;
    sh = 8 - (1 << res);
    return 8'($signed(v) >>> sh);
  endfunction

  task automatic chk(string rq, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1'b1;
    @(negedge clk) s = 1'b0;
  endtask

  task automatic wait_pulse();
    int k;
    k = 0;
    @(negedge clk);
    while (!smp_en_o && k < 40) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic measure(output int gap);
    wait_pulse();
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!smp_en_o && gap < 40);
  endtask

  task automatic wr(int idx, int rate, int res);
    @(negedge clk);
    tbl_we_i = 1'b1; tbl_addr_i = 2'(idx); tbl_wdata_i = {3'(rate), 2'(res)};
    @(negedge clk);
    tbl_we_i = 1'b0;
  endtask

  // open a packet with the given estimate; returns settled gap
  task automatic run_pkt(int idx, output int gap);
    int g;
    pulse(pre_start_i);
    chk("R4 res after preamble start", res_o, 3);
    intf_i = idx[1]; snr_i = idx[0];
    pulse(pre_end_i);
    measure(g);
    measure(gap);
  endtask

  initial begin
    int g;
    logic [7:0] vals [5] = '{8'h80, 8'h7f, 8'hff, 8'h35, 8'hca};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1
    chk("R1 reset res", res_o, 3);
    chk("R1 reset div", div_o, 1);
    chk("R1 reset enable", smp_en_o, 1);
    measure(g);
    chk("R1 reset gap", g, 1);

    // R6 default table contents
    for (int i = 0; i < 4; i++) begin
      int er, ed;
      er = i[0] ? 0 : (i[1] ? 3 : 1);
      ed = i[0] ? 15 : 2;
      run_pkt(i, g);
      chk("R6 default res", res_o, er);
      chk("R6 default gap", g, ed);
      chk("R6 default div", div_o, ed);
      pulse(pkt_end_i);
    end

    // R10: pre_end outside preamble ignored (index 1 holds 1 bit / ratio 15)
    measure(g);
    intf_i = 1'b0; snr_i = 1'b1;
    pulse(pre_end_i);
    chk("R10 pre_end ignored res", res_o, 3);
    measure(g);
    measure(g);
    chk("R10 pre_end ignored gap", g, 1);

    // R7/R8/R5/R3 sweep over every rate and resolution code
    for (int rs = 0; rs < 4; rs++) begin
      for (int rt = 0; rt < 8; rt++) begin
        int idx, eres, erat;
        idx = (rs + rt) % 4;
        smp_i = vals[(rs * 8 + rt) % 5];
        eres = (rt == 7) ? 3 : rs;
        erat = exp_ratio(rt);
        wr(idx, rt, rs);
        run_pkt(idx, g);
        chk((rt == 7) ? "R8 fallback res" : "R5 applied res", res_o, eres);
        chk((rt == 7) ? "R8 fallback gap" : "R7 written ratio gap", g, erat);
        chk("R9 settled div", div_o, erat);
        chk("R3 reduced sample", smp_o, exp_smp(smp_i, eres));
        chk("R2 enable width", smp_en_o, 1);
        @(negedge clk);
        if (erat > 1) chk("R2 enable one cycle", smp_en_o, 0);
        pulse(pkt_end_i);
        chk("R10 packet end res", res_o, 3);
        measure(g);
        measure(g);
        chk("R10 packet end gap", g, 1);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule